// File: doc/BRIEF.md
# Accumulator Data-Path ALU

This block is the purely combinational arithmetic and logic stage of a 24-bit accumulator machine. Each cycle the surrounding core presents the current accumulator, a word fetched from memory and the 20-bit argument field of the instruction, together with a 4-bit operation code. The block returns the value the accumulator should take next, and a sign indication for the conditional branch logic.

The operations are:
- constant load with zero extension;
- a wrapping add of the memory word;
- AND, OR and XOR against the memory word;
- complement of the accumulator;
- an equality test that returns a whole word;
- a one-bit right rotation;
- a wrapping add of a sign-extended 16-bit immediate taken from the argument.

Codes with no operation assigned return the accumulator unchanged. The block holds no registers. It fetches nothing from memory and does not sequence instructions: the core owns storage, fetch and the write-back enable.

Top module: `acc_alu`

## Requirements
- R1: With op_sel = 0 (constant load), acc_out equals instr_arg with bits 23-20 forced to zero.
- R2: With op_sel = 1 (add), acc_out equals acc_in plus mem_opnd modulo 2^24, with no carry output.
- R3: With op_sel = 2, 3 and 4, acc_out is the bitwise AND, OR and XOR, respectively, of acc_in and mem_opnd over all 24 bits.
- R4: With op_sel = 6 (complement), acc_out is the bitwise inverse of acc_in.
- R5: With op_sel = 5 (equality), acc_out is 24'hFFFFFF when acc_in equals mem_opnd and 24'h000000 otherwise, including when they differ only in bit 23.
- R6: With op_sel = 7 (rotate), acc_out is acc_in shifted right by one, with the old bit 0 appearing in bit 23.
- R7: With op_sel = 8 (immediate add), bits 15-0 of instr_arg are read as a two's-complement value and added to acc_in modulo 2^24. Bits 19-16 of instr_arg have no effect.
- R8: acc_neg equals bit 23 of acc_in for every op_sel value.
- R9: op_sel values 9 through 15 return acc_in unchanged on acc_out.
- R10: Operations that take no memory word (codes 0, 6, 7 and 8) give the same acc_out whatever mem_opnd holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_in | input | 24 | Current accumulator value |
| mem_opnd | input | 24 | Word fetched from memory for the operation |
| instr_arg | input | 20 | Argument field of the instruction |
| op_sel | input | 4 | Operation code |
| acc_out | output | 24 | Next accumulator value |
| acc_neg | output | 1 | Sign of the current accumulator |

## Verification
Every result is combinational, so acc_out and acc_neg are due in the same cycle as the inputs that produce them. There is no pipeline latency to count. The bench changes the inputs just after a rising edge and samples the outputs at the following falling edge, half a period later. By then the inputs have settled, and no check depends on the order in which processes run at a clock edge. The checker evaluates its assertions on every change of the ports. Each assertion relates the output to the inputs of the same instant.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD_CONST = 4'd0,
    OP_ADD_MEM    = 4'd1,
    OP_AND_MEM    = 4'd2,
    OP_OR_MEM     = 4'd3,
    OP_XOR_MEM    = 4'd4,
    OP_EQUAL      = 4'd5,
    OP_INVERT     = 4'd6,
    OP_ROTATE     = 4'd7,
    OP_ADD_IMM    = 4'd8
  } acc_op_e;

  typedef enum logic [1:0] {
    LOGIC_AND = 2'd0,
    LOGIC_OR  = 2'd1,
    LOGIC_XOR = 2'd2,
    LOGIC_NOT = 2'd3
  } logic_fn_e;

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] mem_b,
  input  logic [IMM_W-1:0]  imm_b,
  input  logic              use_imm,
  output logic [DATA_W-1:0] sum_o
);

  localparam int unsigned EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] addend;

  generate
    if (EXT_W > 0) begin : g_sext
      assign imm_ext = {{EXT_W{imm_b[IMM_W-1]}}, imm_b};
    end else begin : g_trunc
      assign imm_ext = imm_b[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    addend = use_imm ? imm_ext : mem_b;
    sum_o  = acc_a + addend;
  end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 24
) (
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] mem_b,
  input  logic_fn_e         fn,
  output logic [DATA_W-1:0] res_o
);

  always_comb begin
    unique case (fn)
      LOGIC_AND: res_o = acc_a & mem_b;
      LOGIC_OR:  res_o = acc_a | mem_b;
      LOGIC_XOR: res_o = acc_a ^ mem_b;
      default:   res_o = ~acc_a;
    endcase
  end

endmodule

// File: rtl/acc_alu_rotcmp.sv
module acc_alu_rotcmp #(
  parameter int unsigned DATA_W = 24
) (
  input  logic [DATA_W-1:0] acc_a,
  input  logic [DATA_W-1:0] mem_b,
  output logic [DATA_W-1:0] rot_o,
  output logic [DATA_W-1:0] eq_o
);

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_rot
      assign rot_o[gi] = acc_a[(gi + 1) % DATA_W];
    end
  endgenerate

  logic same;
  always_comb begin
    same = (acc_a == mem_b);
    eq_o = {DATA_W{same}};
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ARG_W  = 20,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] mem_opnd,
  input  logic [ARG_W-1:0]  instr_arg,
  input  logic [OP_W-1:0]   op_sel,
  output logic [DATA_W-1:0] acc_out,
  output logic              acc_neg
);

  localparam int unsigned PAD_W = DATA_W - ARG_W;

  logic [DATA_W-1:0] const_word;
  logic [DATA_W-1:0] sum_word;
  logic [DATA_W-1:0] logic_word;
  logic [DATA_W-1:0] rot_word;
  logic [DATA_W-1:0] eq_word;
  logic              imm_sel;
  logic_fn_e         lfn;
  acc_op_e           op;

  assign op = acc_op_e'(op_sel);

  generate
    if (PAD_W > 0) begin : g_pad
      assign const_word = {{PAD_W{1'b0}}, instr_arg};
    end else begin : g_nopad
      assign const_word = instr_arg[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    imm_sel = (op == OP_ADD_IMM);
    unique case (op)
      OP_AND_MEM: lfn = LOGIC_AND;
      OP_OR_MEM:  lfn = LOGIC_OR;
      OP_XOR_MEM: lfn = LOGIC_XOR;
      default:    lfn = LOGIC_NOT;
    endcase
  end

  acc_alu_adder #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_adder (
    .acc_a   (acc_in),
    .mem_b   (mem_opnd),
    .imm_b   (instr_arg[IMM_W-1:0]),
    .use_imm (imm_sel),
    .sum_o   (sum_word)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .acc_a (acc_in),
    .mem_b (mem_opnd),
    .fn    (lfn),
    .res_o (logic_word)
  );

  acc_alu_rotcmp #(.DATA_W(DATA_W)) u_rotcmp (
    .acc_a (acc_in),
    .mem_b (mem_opnd),
    .rot_o (rot_word),
    .eq_o  (eq_word)
  );

  always_comb begin
    acc_neg = acc_in[DATA_W-1];
    case (op)
      OP_LOAD_CONST: acc_out = const_word;
      OP_ADD_MEM,
      OP_ADD_IMM:    acc_out = sum_word;
      OP_AND_MEM,
      OP_OR_MEM,
      OP_XOR_MEM,
      OP_INVERT:     acc_out = logic_word;
      OP_EQUAL:      acc_out = eq_word;
      OP_ROTATE:     acc_out = rot_word;
      default:       acc_out = acc_in;
    endcase
  end

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned ARG_W  = 20,
  parameter int unsigned IMM_W  = 16
) (
  input logic [DATA_W-1:0] acc_in,
  input logic [DATA_W-1:0] mem_opnd,
  input logic [ARG_W-1:0]  instr_arg,
  input logic [3:0]        op_sel,
  input logic [DATA_W-1:0] acc_out,
  input logic              acc_neg
);

  logic [DATA_W-1:0] diff;
  logic [IMM_W-1:0]  imm_low;

  always_comb begin
    diff    = acc_out - acc_in;
    imm_low = instr_arg[IMM_W-1:0];

    if (op_sel == 4'd0) begin
      assert_const_top_zero_R1: assert (acc_out[DATA_W-1:ARG_W] == '0)
        else $error("constant load left upper bits set");
    end
    if (op_sel == 4'd1) begin
      assert_add_diff_R2: assert (diff == mem_opnd)
        else $error("add result minus accumulator differs from operand");
    end
    if (op_sel == 4'd6) begin
      assert_not_disjoint_R4: assert (((acc_out & acc_in) == '0) && ((acc_out | acc_in) == '1))
        else $error("complement overlaps its input");
    end
    if (op_sel == 4'd5) begin
      assert_eq_word_R5: assert ($countones(acc_out) == 0 || $countones(acc_out) == DATA_W)
        else $error("equality result is not a whole word");
    end
    if (op_sel == 4'd7) begin
      assert_rot_ones_R6: assert (($countones(acc_out) == $countones(acc_in)) && (acc_out[DATA_W-1] == acc_in[0]))
        else $error("rotation lost or misplaced a bit");
    end
    if (op_sel == 4'd8) begin
      assert_imm_diff_R7: assert ((diff[IMM_W-1:0] == imm_low) && ($countones(diff[DATA_W-1:IMM_W]) == (imm_low[IMM_W-1] ? DATA_W-IMM_W : 0)))
        else $error("immediate add differs from sign-extended immediate");
    end
    assert_neg_sign_R8: assert (acc_neg == acc_in[DATA_W-1])
      else $error("sign output disagrees with accumulator");
    if (op_sel >= 4'd9) begin
      assert_unused_pass_R9: assert (acc_out == acc_in)
        else $error("unused code changed accumulator");
    end
  end

endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W), .ARG_W(ARG_W), .IMM_W(IMM_W)) u_acc_alu_checker (
  .acc_in    (acc_in),
  .mem_opnd  (mem_opnd),
  .instr_arg (instr_arg),
  .op_sel    (op_sel),
  .acc_out   (acc_out),
  .acc_neg   (acc_neg)
);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  logic        clk;
  logic        rst_n;
  logic [23:0] acc_in;
  logic [23:0] mem_opnd;
  logic [19:0] instr_arg;
  logic [3:0]  op_sel;
  logic [23:0] acc_out;
  logic        acc_neg;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  acc_alu u_acc_alu (
    .acc_in    (acc_in),
    .mem_opnd  (mem_opnd),
    .instr_arg (instr_arg),
    .op_sel    (op_sel),
    .acc_out   (acc_out),
    .acc_neg   (acc_neg)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] op, input logic [23:0] a,
                       input logic [23:0] m, input logic [19:0] g);
    @(posedge clk);
    #1;
    op_sel = op; acc_in = a; mem_opnd = m; instr_arg = g;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    apply(4'd0, 24'h0, 24'h0, 20'h0);
    check("R1 reset", acc_out, 24'h0);
    check("R8 reset", {23'b0, acc_neg}, 24'h0);
    rst_n = 1'b1;
  endtask

  task automatic t_load_const;
    apply(4'd0, 24'hFFFFFF, 24'h123456, 20'hABCDE);
    check("R1", acc_out, 24'h0ABCDE);
    apply(4'd0, 24'h000000, 24'hFFFFFF, 20'hFFFFF);
    check("R1 R10", acc_out, 24'h0FFFFF);
  endtask

  task automatic t_add;
    apply(4'd1, 24'h123456, 24'h111111, 20'h0);
    check("R2", acc_out, 24'h234567);
    apply(4'd1, 24'hFFFFFF, 24'h000002, 20'hFFFFF);
    check("R2 wrap", acc_out, 24'h000001);
  endtask

  task automatic t_bitwise;
    apply(4'd2, 24'hF0F0AA, 24'h3C3C55, 20'h0);
    check("R3 and", acc_out, 24'h303000);
    apply(4'd3, 24'hF0F0AA, 24'h3C3C55, 20'h0);
    check("R3 or", acc_out, 24'hFCFCFF);
    apply(4'd4, 24'hF0F0AA, 24'h3C3C55, 20'h0);
    check("R3 xor", acc_out, 24'hCCCCFF);
    apply(4'd6, 24'h0F00FF, 24'h123456, 20'h0);
    check("R4", acc_out, 24'hF0FF00);
    apply(4'd6, 24'h0F00FF, 24'hFEDCBA, 20'h0);
    check("R4 R10", acc_out, 24'hF0FF00);
  endtask

  task automatic t_equal;
    apply(4'd5, 24'h5A5A5A, 24'h5A5A5A, 20'h0);
    check("R5 equal", acc_out, 24'hFFFFFF);
    apply(4'd5, 24'h5A5A5A, 24'hDA5A5A, 20'h0);
    check("R5 bit23", acc_out, 24'h000000);
    apply(4'd5, 24'h000000, 24'h000001, 20'h0);
    check("R5 bit0", acc_out, 24'h000000);
  endtask

  task automatic t_rotate;
    apply(4'd7, 24'h000001, 24'h0, 20'h0);
    check("R6 wrap", acc_out, 24'h800000);
    apply(4'd7, 24'h800002, 24'hFFFFFF, 20'hFFFFF);
    check("R6 R10", acc_out, 24'h400001);
  endtask

  task automatic t_add_imm;
    apply(4'd8, 24'h000010, 24'h0, 20'hFFFFF);
    check("R7 minus1", acc_out, 24'h00000F);
    apply(4'd8, 24'hFFFFFF, 24'h0, 20'h07FFF);
    check("R7 maxpos", acc_out, 24'h007FFE);
    apply(4'd8, 24'h000000, 24'h0, 20'hA8000);
    check("R7 minneg", acc_out, 24'hFF8000);
    apply(4'd8, 24'h000000, 24'hABCDEF, 20'h58000);
    check("R7 upper ignored R10", acc_out, 24'hFF8000);
  endtask

  task automatic t_sign;
    for (int op = 0; op < 16; op++) begin
      apply(op[3:0], 24'h800000, 24'h0, 20'h1);
      check("R8 set", {23'b0, acc_neg}, 24'h1);
    end
    apply(4'd6, 24'h7FFFFF, 24'h0, 20'h0);
    check("R8 clear", {23'b0, acc_neg}, 24'h0);
  endtask

  task automatic t_unused;
    for (int op = 9; op < 16; op++) begin
      apply(op[3:0], 24'hC3A51E, 24'h0F0F0F, 20'h12345);
      check("R9", acc_out, 24'hC3A51E);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    acc_in = '0; mem_opnd = '0; instr_arg = '0; op_sel = '0;
    t_reset();
    t_load_const();
    t_add();
    t_bitwise();
    t_equal();
    t_rotate();
    t_add_imm();
    t_sign();
    t_unused();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

endmodule